// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles the outcome of a short relative branch for an 8-bit processor core. The decoder passes in the low four bits of a branch opcode and the four arithmetic condition flags: negative, zero, overflow and carry. The block reports whether the branch is taken. It also returns the program counter to use next.

Every relative branch occupies two bytes, so the caller supplies the address that follows the displacement byte. When the branch is taken, the block adds the sign-extended displacement to that address, and the sum wraps modulo the address space. When the branch is not taken, the block passes the address through unchanged.

Codes come in pairs that share one condition. The even code branches when the condition is false and the odd code branches when it is true. The pairs cover the unconditional case, the unsigned comparisons, single-flag tests and the signed comparisons. The block is purely combinational, so both outputs settle in the same cycle as the inputs.

Top module: `branch_resolve`

## Requirements
- R1: Code 0x0 is taken for every flag combination.
- R2: Code 0x1 is never taken.
- R3: Codes 0x2 and 0x3 test carry OR zero. Code 0x2 is taken when the result is 0 (unsigned higher). Code 0x3 is taken when the result is 1 (lower or same).
- R4: Code 0x4 is taken when carry is 0. Code 0x5 is taken when carry is 1.
- R5: Code 0x6 is taken when zero is 0. Code 0x7 is taken when zero is 1.
- R6: Code 0x8 is taken when overflow is 0. Code 0x9 is taken when overflow is 1.
- R7: Code 0xA is taken when negative is 0. Code 0xB is taken when negative is 1.
- R8: Code 0xC is taken when negative XOR overflow is 0. Code 0xD is taken when negative XOR overflow is 1.
- R9: Code 0xE is taken when zero OR (negative XOR overflow) is 0. Code 0xF is taken when that expression is 1.
- R10: When the branch is taken, `new_pc` equals `next_pc` plus the two's-complement value of `disp`, modulo 2^16. This includes -128 (0x80), +127 (0x7F), and sums that wrap past 0xFFFF or below 0x0000.
- R11: When the branch is not taken, `new_pc` equals `next_pc`, whatever the value of `disp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| br_code | input | 4 | Low nibble of the branch opcode |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| next_pc | input | 16 | Address of the instruction after the branch |
| disp | input | 8 | Signed branch displacement |
| take_o | output | 1 | High when the branch is taken |
| new_pc | output | 16 | Program counter to continue from |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit displacement. With these widths, wrap-around in both directions can be reached with small addresses near 0x0000 and 0xFFFF. An exhaustive sweep covers all sixteen codes against all sixteen flag combinations, and that space stays small enough to enumerate at the default widths. A vector table and directed cases target the extreme displacements, and they confirm that a nonzero displacement leaves the address unchanged on a branch that is not taken.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [3:0]        br_code,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DISP_W-1:0] disp,
  output logic              take_o,
  output logic [ADDR_W-1:0] new_pc
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic              pair_cond;
  logic              take_v;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] pc_v;

  always_comb begin
    // even code branches on the false sense, odd code inverts it
    unique case (br_code[3:1])
      3'd0: pair_cond = 1'b1;
      3'd1: pair_cond = ~(flag_c | flag_z);
      3'd2: pair_cond = ~flag_c;
      3'd3: pair_cond = ~flag_z;
      3'd4: pair_cond = ~flag_v;
      3'd5: pair_cond = ~flag_n;
      3'd6: pair_cond = ~(flag_n ^ flag_v);
      default: pair_cond = ~(flag_z | (flag_n ^ flag_v));
    endcase
    take_v = pair_cond ^ br_code[0];
    offset = {{EXT_W{disp[DISP_W-1]}}, disp};
    pc_v   = take_v ? next_pc + offset : next_pc;

    // R1
    always_taken_chk: assert (br_code != 4'h0 || take_v)
      else $error("code 0 not taken");
    // R2
    never_taken_chk: assert (br_code != 4'h1 || !take_v)
      else $error("code 1 taken");
    // R3
    unsigned_hi_chk: assert (br_code != 4'h2 || take_v == (!flag_c && !flag_z))
      else $error("higher decision wrong");
    // R9
    signed_le_chk: assert (br_code != 4'hF || take_v == (flag_z || (flag_n != flag_v)))
      else $error("less-or-equal decision wrong");
    // R11
    hold_pc_chk: assert (take_v || pc_v == next_pc)
      else $error("pc moved on a branch that was not taken");
    // R10
    target_pc_chk: assert (!take_v || (pc_v - next_pc) == offset)
      else $error("taken target wrong");
  end

  assign take_o = take_v;
  assign new_pc = pc_v;

endmodule

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  br_code;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic [15:0] next_pc;
  logic [7:0]  disp;
  logic        take_o;
  logic [15:0] new_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  branch_resolve #(.ADDR_W(16), .DISP_W(8)) uut (
    .br_code(br_code), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .next_pc(next_pc), .disp(disp),
    .take_o(take_o), .new_pc(new_pc)
  );

  // {code, nzvc, next_pc, disp, taken, new_pc}
  localparam int NV = 16;
  localparam logic [48:0] VEC [NV] = '{
    {4'h0, 4'b0000, 16'h1000, 8'h05, 1'b1, 16'h1005},
    {4'h1, 4'b1111, 16'h1000, 8'h05, 1'b0, 16'h1000},
    {4'h2, 4'b0000, 16'h2000, 8'hFE, 1'b1, 16'h1FFE},
    {4'h2, 4'b0001, 16'h2000, 8'hFE, 1'b0, 16'h2000},
    {4'h3, 4'b0100, 16'h2000, 8'h10, 1'b1, 16'h2010},
    {4'h4, 4'b0000, 16'h3000, 8'h80, 1'b1, 16'h2F80},
    {4'h5, 4'b0000, 16'h3000, 8'h80, 1'b0, 16'h3000},
    {4'h7, 4'b0100, 16'hFFF0, 8'h20, 1'b1, 16'h0010},
    {4'h9, 4'b0010, 16'h0005, 8'hF0, 1'b1, 16'hFFF5},
    {4'hB, 4'b1000, 16'h4000, 8'h7F, 1'b1, 16'h407F},
    {4'hC, 4'b1010, 16'h4000, 8'h01, 1'b1, 16'h4001},
    {4'hD, 4'b1000, 16'h4000, 8'h01, 1'b1, 16'h4001},
    {4'hE, 4'b0100, 16'h5000, 8'h02, 1'b0, 16'h5000},
    {4'hF, 4'b0010, 16'h5000, 8'h02, 1'b1, 16'h5002},
    {4'h6, 4'b0000, 16'h0000, 8'hFF, 1'b1, 16'hFFFF},
    {4'hA, 4'b1000, 16'h1234, 8'h00, 1'b0, 16'h1234}
  };

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4, 4'h5: return "R4";
      4'h6, 4'h7: return "R5";
      4'h8, 4'h9: return "R6";
      4'hA, 4'hB: return "R7";
      4'hC, 4'hD: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit ref_take(input logic [3:0] c, input logic [3:0] f);
    bit n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      4'h0: return 1;
      4'h1: return 0;
      4'h2: return (cy == 0 && z == 0);
      4'h3: return (cy == 1 || z == 1);
      4'h4: return cy == 0;
      4'h5: return cy == 1;
      4'h6: return z == 0;
      4'h7: return z == 1;
      4'h8: return v == 0;
      4'h9: return v == 1;
      4'hA: return n == 0;
      4'hB: return n == 1;
      4'hC: return n == v;
      4'hD: return n != v;
      4'hE: return (z == 0 && n == v);
      default: return (z == 1 || n != v);
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [3:0] f,
                       input logic [15:0] pc, input logic [7:0] d);
    br_code = c;
    {flag_n, flag_z, flag_v, flag_c} = f;
    next_pc = pc;
    disp = d;
    #1;
  endtask

  task automatic check_take(input string r, input logic exp);
    checks++;
    if (take_o !== exp) begin
      fails++;
      $display("FAIL %s take_o actual=%0b expected=%0b (code=%h)", r, take_o, exp, br_code);
    end
  endtask

  task automatic check_pc(input string r, input logic [15:0] exp);
    checks++;
    if (new_pc !== exp) begin
      fails++;
      $display("FAIL %s new_pc actual=%h expected=%h (code=%h)", r, new_pc, exp, br_code);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] exp_pc;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][48:45], VEC[i][44:41], VEC[i][40:25], VEC[i][24:17]);
      check_take(req_of(VEC[i][48:45]), VEC[i][16]);
      check_pc(VEC[i][16] ? "R10" : "R11", VEC[i][15:0]);
      @(negedge clk);
    end

    // exhaustive decisions R1..R9, with pc rule R10/R11
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(c[3:0], f[3:0], 16'h8000, 8'hC0);
        check_take(req_of(c[3:0]), ref_take(c[3:0], f[3:0]));
        exp_pc = ref_take(c[3:0], f[3:0]) ? 16'h7FC0 : 16'h8000;
        check_pc(ref_take(c[3:0], f[3:0]) ? "R10" : "R11", exp_pc);
      end
      @(negedge clk);
    end

    // R10 extremes
    apply(4'h0, 4'b0000, 16'h0000, 8'h80);
    check_pc("R10", 16'hFF80);
    apply(4'h0, 4'b0000, 16'hFFFF, 8'h7F);
    check_pc("R10", 16'h007E);
    apply(4'h0, 4'b0000, 16'hFFFF, 8'h01);
    check_pc("R10", 16'h0000);
    // R11 large displacement ignored when not taken
    apply(4'h1, 4'b0000, 16'hABCD, 8'h7F);
    check_take("R2", 1'b0);
    check_pc("R11", 16'hABCD);
    apply(4'h5, 4'b0000, 16'h0000, 8'h80);
    check_pc("R11", 16'h0000);

    finish_run();
  end
endmodule